// File: doc/BRIEF.md
# Programmable Reed-Solomon parity encoder

This block is a systematic Reed-Solomon encoder for 8-bit symbols over GF(256). It takes in one symbol per clock. Each code block is sent out as the original data symbols, unchanged, followed directly by r check symbols. The check count r is even, from 0 to 20. It is loaded as r/2 on a 4-bit strength bus during a timed reset sequence. After that it stays fixed until the next reset.

To frame a block, the user raises both the input enable and the output-select enable with the first data symbol and keeps them high for all k data symbols. The user then drops both enables for r clocks. During those clocks the parity register is fed zeros, and its contents are shifted out behind the data. Every output lags its input by three clocks. A ready flag carries the input enable through the same three-clock delay. The data length k may change from block to block. With r = 0 the block only delays the input. A separate disable input marks the output as not valid and has no effect on encoding.

Top module: `rs_parity_enc`

## Requirements
- R1: Each emitted codeword (k data symbols, then r check symbols, first symbol treated as the highest-degree coefficient) evaluates to zero at α^0 … α^(r−1). Arithmetic uses x^8+x^4+x^3+x^2+1, with α = 0x02.
- R2: While `rst_n` and `en_in` are both low, `strength` is captured as r/2. Values above 10 are treated as 10. While `rst_n` is high, `strength` has no effect.
- R3: `dout` equals the symbol selected three clocks earlier. Data symbols (output-select high) come out bit-for-bit unchanged.
- R4: `rdy` equals `en_in` delayed by three clocks.
- R5: The r check symbols come out directly after the last data symbol, one per clock, highest-degree remainder coefficient first.
- R6: While `en_in` is low, zero is fed to the parity register instead of `din`. The value on `din` during the drain does not affect the check symbols.
- R7: The parity register restarts from zero on the first data symbol of each block. Blocks sent back to back with different k are each valid codewords.
- R8: With r = 0, `dout` equals `din` delayed by three clocks, whatever the output-select enable is.
- R9: `dout_vld` is low while `out_dis` is high and high otherwise. Encoding continues unaffected.
- R10: After one clock with `rst_n` low, `dout` is 0x00 and `rdy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low reset; also opens the strength capture window |
| en_in | input | 1 | Input enable: data feeds the parity register when high, zero when low |
| en_out | input | 1 | Output select: input data when high, check symbols when low |
| out_dis | input | 1 | Output disable |
| strength | input | 4 | r/2, sampled during reset |
| din | input | 8 | Input symbol |
| dout | output | 8 | Output symbol |
| dout_vld | output | 1 | Output valid (low when disabled) |
| rdy | output | 1 | Input enable delayed three clocks |

## Verification
The bench builds the block with its default maximum of 20 check symbols. This allows every strength from 0 to 10 to be tested, including full 255-symbol blocks at r = 20 and a strength of 15 that must clamp to 20. A table of (r/2, k, seed) rows sends one block per row and checks each one with a syndrome computation in the bench. Directed cases cover back-to-back blocks of different k, drains with different junk on `din`, pass-through at r = 0, output disable, and the reset state.

// File: rtl/rs_parity_enc.sv
module rs_parity_enc #(
  parameter int MAX_R = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_in,
  input  logic       en_out,
  input  logic       out_dis,
  input  logic [3:0] strength,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_vld,
  output logic       rdy
);
  localparam int MAX_HALF = MAX_R / 2;
  localparam int LAT      = 3;
  localparam int GW       = 8 * MAX_R;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = {aa[6:0], 1'b0} ^ (aa[7] ? 8'h1D : 8'h00);
    end
    return acc;
  endfunction

  function automatic logic [GW-1:0] gen_poly(input int nr);
    logic [8*(MAX_R+1)-1:0] g;
    logic [7:0] a;
    g = '0;
    g[7:0] = 8'h01;
    a = 8'h01;
    for (int i = 0; i < MAX_R; i++) begin
      if (i < nr) begin
        for (int j = MAX_R; j > 0; j--)
          g[8*j +: 8] = g[8*(j-1) +: 8] ^ gmul(g[8*j +: 8], a);
        g[7:0] = gmul(g[7:0], a);
        a = gmul(a, 8'h02);
      end
    end
    return g[GW-1:0];
  endfunction

  logic [GW-1:0] gtab [0:MAX_HALF];
  for (genvar h = 0; h <= MAX_HALF; h++) begin : g_gen
    localparam logic [GW-1:0] GH = gen_poly(2 * h);
    assign gtab[h] = GH;
  end

  logic [3:0] half_q;
  logic [5:0] nr;
  logic       en_in_q, first;
  logic [7:0] p [0:MAX_R-1];
  logic [7:0] p_nxt [0:MAX_R-1];
  logic [7:0] p_top, fb, src;
  logic [GW-1:0] gsel;
  logic [7:0] dpipe [0:LAT-1];
  logic [LAT-1:0] rpipe;

  always_ff @(posedge clk)
    if (!rst_n && !en_in)
      half_q <= (int'(strength) > MAX_HALF) ? 4'(MAX_HALF) : strength;

  assign nr    = {1'b0, half_q, 1'b0};
  assign first = en_in && !en_in_q;
  assign gsel  = gtab[half_q];

  always_comb begin
    p_top = 8'h00;
    for (int j = 0; j < MAX_R; j++)
      if (j == int'(nr) - 1 && !first) p_top = p[j];
  end

  assign fb  = en_in ? (din ^ p_top) : 8'h00;
  assign src = (en_out || half_q == 4'd0) ? din : p_top;

  always_comb begin
    for (int j = 0; j < MAX_R; j++) begin
      p_nxt[j] = 8'h00;
      if (j < int'(nr)) begin
        if (j > 0 && !first) p_nxt[j] = p[j-1];
        p_nxt[j] = p_nxt[j] ^ gmul(fb, gsel[8*j +: 8]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_in_q <= 1'b0;
      rpipe   <= '0;
      for (int j = 0; j < MAX_R; j++) p[j] <= 8'h00;
      for (int s = 0; s < LAT; s++) dpipe[s] <= 8'h00;
    end else begin
      en_in_q <= en_in;
      rpipe   <= {rpipe[LAT-2:0], en_in};
      for (int j = 0; j < MAX_R; j++) p[j] <= p_nxt[j];
      dpipe[0] <= src;
      for (int s = 1; s < LAT; s++) dpipe[s] <= dpipe[s-1];
    end
  end

  assign dout     = dpipe[LAT-1];
  assign rdy      = rpipe[LAT-1];
  assign dout_vld = !out_dis;

  logic [1:0] since_rst;
  always_ff @(posedge clk)
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  assert_ready_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (rdy == $past(en_in, 3)));
  assert_data_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(en_out, 3)) |-> (dout == $past(din, 3)));
  assert_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && half_q == 4'd0) |-> (dout == $past(din, 3)));
  assert_strength_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd0) |-> $stable(half_q));
  assert_zero_feed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_in |=> (p[0] == 8'h00));
endmodule

// File: tb/sim_rs_parity_enc.sv
module sim_rs_parity_enc;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, en_in = 1'b0, en_out = 1'b0, out_dis = 1'b0;
  logic [3:0] strength = 4'd0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       dout_vld, rdy;

  rs_parity_enc u0 (.clk(clk), .rst_n(rst_n), .en_in(en_in), .en_out(en_out),
    .out_dis(out_dis), .strength(strength), .din(din), .dout(dout),
    .dout_vld(dout_vld), .rdy(rdy));

  int checks = 0, fails = 0, n = 0;
  bit done = 0;
  logic [7:0] ob [0:1023];
  logic [7:0] ib [0:1023];
  logic       rb [0:1023];
  logic       ie [0:1023];
  logic [7:0] par_a [0:19];

  // (r/2, k, seed)
  localparam logic [15:0] VEC [0:6] = '{16'h1051, 16'h2102, 16'h4013, 16'h5284,
                                         16'h8645, 16'hAEB6, 16'h3037};

  function automatic logic [7:0] fm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      r = {r[6:0], 1'b0} ^ (r[7] ? 8'h1D : 8'h00);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [7:0] dat(input int seed, input int i);
    return 8'((seed * 71) + (i * 29) + ((i * i) >> 2));
  endfunction

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic cyc(input logic ei, input logic eo, input logic [7:0] d);
    @(negedge clk);
    ob[n] = dout; rb[n] = rdy;
    en_in = ei; en_out = eo; din = d;
    ie[n] = ei; ib[n] = d;
    n++;
  endtask

  task automatic init(input logic [3:0] h);
    @(negedge clk);
    rst_n = 0; en_in = 0; en_out = 0; strength = h;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    strength = 4'hF; // R2: ignored while reset is high
  endtask

  task automatic feed(input int k, input int r, input int seed, input int junk);
    for (int i = 0; i < k; i++) cyc(1, 1, dat(seed, i));
    for (int i = 0; i < r; i++) cyc(0, 0, (junk == 0) ? 8'h00 : 8'(i * 53 + 7));
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) cyc(0, 0, 8'hA5);
  endtask

  task automatic verify(input int s, input int k, input int r, input string tag);
    int bad_i;
    logic [7:0] syn, a;
    bad_i = -1;
    for (int i = 0; i < k; i++)
      if (bad_i < 0 && ob[s+3+i] !== ib[s+i]) bad_i = i;
    chk(bad_i < 0, $sformatf("R3 data unchanged %s", tag),
        (bad_i < 0) ? 0 : ob[s+3+bad_i], (bad_i < 0) ? 0 : ib[s+bad_i]);
    syn = 8'h00;
    a = 8'h01;
    for (int j = 0; j < r; j++) begin
      logic [7:0] sj = 8'h00;
      for (int i = 0; i < k + r; i++) sj = fm(sj, a) ^ ob[s+3+i];
      if (syn == 8'h00) syn = sj;
      a = fm(a, 8'h02);
    end
    chk(syn == 8'h00, $sformatf("R1 R5 syndrome %s", tag), syn, 0);
    bad_i = -1;
    for (int m = s; m < s + k + r; m++)
      if (bad_i < 0 && rb[m+3] !== ie[m]) bad_i = m;
    chk(bad_i < 0, $sformatf("R4 rdy delay %s", tag),
        (bad_i < 0) ? 0 : rb[bad_i+3], (bad_i < 0) ? 0 : ie[bad_i]);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    // R10: reset state
    init(4'd2);
    chk(dout == 8'h00 && rdy == 1'b0, "R10 reset state", {dout, 7'b0, rdy}, 0);

    // table of vectors, one block each
    foreach (VEC[v]) begin
      int h, k, sd;
      h = int'(VEC[v][15:12]); k = int'(VEC[v][11:4]); sd = int'(VEC[v][3:0]);
      init(4'(h));
      n = 0;
      feed(k, 2 * h, sd, 1);
      flush();
      verify(0, k, 2 * h, $sformatf("vec%0d r=%0d k=%0d", v, 2 * h, k));
    end

    // R2: strength above 10 clamps to r=20
    init(4'd15);
    n = 0; feed(30, 20, 9, 1); flush();
    verify(0, 30, 20, "R2 clamp r=20");

    // R7: back-to-back blocks with different k
    init(4'd3);
    n = 0;
    feed(9, 6, 11, 1);
    feed(25, 6, 12, 1);
    feed(7, 6, 13, 0);
    flush();
    verify(0, 9, 6, "R7 blk0");
    verify(15, 25, 6, "R7 blk1");
    verify(46, 7, 6, "R7 blk2");

    // R6: drain junk does not change parity
    init(4'd4);
    n = 0; feed(12, 8, 3, 0); flush();
    for (int i = 0; i < 8; i++) par_a[i] = ob[3+12+i];
    n = 0; feed(12, 8, 3, 1); flush();
    begin
      int bad = -1;
      for (int i = 0; i < 8; i++) if (bad < 0 && ob[3+12+i] !== par_a[i]) bad = i;
      chk(bad < 0, "R6 parity independent of din during drain",
          (bad < 0) ? 0 : ob[3+12+bad], (bad < 0) ? 0 : par_a[bad]);
    end
    verify(0, 12, 8, "R6 junk drain");

    // R8: r=0 pass-through irrespective of en_out
    init(4'd0);
    n = 0;
    for (int i = 0; i < 20; i++) cyc(1, i[0], dat(5, i));
    for (int i = 0; i < 6; i++) cyc(0, 0, 8'(i + 100));
    flush();
    begin
      int bad = -1;
      for (int i = 0; i < 26; i++) if (bad < 0 && ob[i+3] !== ib[i]) bad = i;
      chk(bad < 0, "R8 pass-through", (bad < 0) ? 0 : ob[bad+3], (bad < 0) ? 0 : ib[bad]);
    end

    // R9: output disable
    init(4'd2);
    out_dis = 1; #1;
    chk(dout_vld == 1'b0, "R9 valid low when disabled", dout_vld, 0);
    n = 0; feed(10, 4, 8, 1); flush();
    verify(0, 10, 4, "R9 encode while disabled");
    out_dis = 0; #1;
    chk(dout_vld == 1'b1, "R9 valid high when enabled", dout_vld, 1);

    finish_up();
  end
endmodule